// File: doc/BRIEF.md
# Level-Latching Interrupt Controller with Event Counters

This block collects 32 level-sensitive interrupt lines into one interrupt request toward a processor. Each line is brought into the clock domain by a two-flop synchronizer, and the synchronized value forms a live-level word. Every cycle, the live-level word is ORed into a sticky pending word. An enable mask selects which pending bits may drive the processor request.

Software clears pending bits by writing a word whose set bits name the bits to drop. Because the live levels are ORed back in during the same update, a line that is still asserted stays pending after an acknowledge. Every line also owns a 64-bit counter that counts synchronized low-to-high transitions.

All state is reached through a small synchronous port with separate read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_latch_ctrl`

## Requirements
- R1: The live-level word (read at address 2) shows each input after a two-flop synchronizer. A change that is driven before clock edge k is visible after edge k+2. After edge k+1 the word still holds the old value.
- R2: On every clock, the pending word becomes its previous value ORed with the synchronized inputs. An input that goes low never clears a pending bit.
- R3: The processor request `cpu_irq` is high exactly when pending AND mask is nonzero. It follows mask writes, acknowledges and input changes with no further cycle of delay beyond the state update.
- R4: A write to address 1 is an acknowledge. Each set bit of the written word clears the matching pending bit, except where the synchronized input is high in that same cycle; in that case the bit stays pending.
- R5: A write to address 0 replaces the whole mask with the written word. The mask reads back at address 0.
- R6: Reset (active-low `rst_n`) clears the mask, the pending word, the live-level word, the synchronizer and all 32 counters to zero, and drives `cpu_irq` low.
- R7: Each line's 64-bit counter increments by one per synchronized low-to-high transition. It does not increment while the line stays high.
- R8: A read strobe returns data on `rd_data` after the next clock edge. The address map is as follows. Address 0 reads the mask. Address 1 reads the pending word. Address 2 reads the live-level word. Address 3 reads zero. When address bit 6 is 1, bits 5:1 pick the line and bit 0 picks the counter half: 0 for the low 32 bits, 1 for the high 32 bits.
- R9: Writes to the live-level address, to address 3 or to counter addresses have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A table of vectors drives the main function. Each vector applies an input pattern, a mask and an acknowledge, and the expected values come from a small pending model. The patterns cover the following cases:
- a single low line, showing that pending is latched;
- a released line that stays pending under a mask, showing that pending is sticky;
- an acknowledge of a line that is already low, showing that the bit clears;
- an acknowledge that lands in the same cycle as a new assertion, showing that the assertion wins;
- a wide mixed pattern against a one-bit mask, showing that the mask selects.

Directed tests cover the following:
- counting pulses against a level that is held high, which separates edge counting from level counting;
- the synchronizer latency, edge by edge;
- writes to read-only addresses, whose results are read back.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NUM_IRQ = 32,
  parameter int CNT_W   = 64,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              cpu_irq
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(1);

  logic [NUM_IRQ-1:0] meta_q, sync_q, level_q, pend_q, mask_q;
  logic [CNT_W-1:0]   cnt_q [NUM_IRQ];
  logic [DATA_W-1:0]  rd_mux;

  wire                wr_mask = wr_en && addr == A_MASK;
  wire                wr_ack  = wr_en && addr == A_ACK;
  wire [NUM_IRQ-1:0]  ack_bits = wr_ack ? wr_data[NUM_IRQ-1:0] : '0;
  wire [NUM_IRQ-1:0]  rise = sync_q & ~level_q;

  assign cpu_irq = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      sync_q  <= '0;
      level_q <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
    end else begin
      meta_q  <= irq_in;
      sync_q  <= meta_q;
      level_q <= sync_q;
      pend_q  <= (pend_q & ~ack_bits) | sync_q;
      if (wr_mask) mask_q <= wr_data[NUM_IRQ-1:0];
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q[g] <= '0;
      else if (rise[g]) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr[ADDR_W-1]) begin
      if (addr[0]) rd_mux = DATA_W'(cnt_q[addr[IDX_W:1]] >> DATA_W);
      else         rd_mux = cnt_q[addr[IDX_W:1]][DATA_W-1:0];
    end else begin
      case (addr[1:0])
        2'd0:    rd_mux = DATA_W'(mask_q);
        2'd1:    rd_mux = DATA_W'(pend_q);
        2'd2:    rd_mux = DATA_W'(level_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int NUM_IRQ = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NUM_IRQ-1:0] level_q,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] mask_q
);
  wire is_ack  = wr_en && addr == ADDR_W'(1);
  wire is_mask = wr_en && addr == ADDR_W'(0);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ack |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r2_level_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q & ~pend_q) == '0);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_ack |=> ((pend_q & $past(wr_data[NUM_IRQ-1:0]) & ~level_q) == '0));

  a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    is_mask |=> (mask_q == $past(wr_data[NUM_IRQ-1:0])));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .level_q(level_q), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/test_irq_latch_ctrl.sv
`timescale 1ns/1ps
module test_irq_latch_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [6:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cpu_irq;
  int errors = 0, checks = 0;
  logic [31:0] pend_m = '0;
  logic [31:0] got;

  always #5 clk = ~clk;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq)
  );

  // {irq_in, mask, ack}
  localparam logic [95:0] VEC [8] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0001, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0001, 32'h0000_0001},
    {32'h8000_0010, 32'h8000_0000, 32'h8000_0000},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'hA5A5_0F0F, 32'h0000_0100, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0100, 32'h0000_0F0F},
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; irq_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [6:0] cnt_addr(input int idx, input bit hi);
    return {1'b1, 5'(idx), hi};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R6: reset state
    check({31'b0, cpu_irq}, 32'h0, "R6 cpu_irq");
    rd(7'd0, got); check(got, 32'h0, "R6 mask");
    rd(7'd1, got); check(got, 32'h0, "R6 pending");
    rd(7'd2, got); check(got, 32'h0, "R6 level");
    rd(cnt_addr(7, 0), got); check(got, 32'h0, "R6 counter");

    // R2 R3 R4 R5: vector table
    foreach (VEC[i]) begin
      logic [31:0] v_irq, v_mask, v_ack;
      {v_irq, v_mask, v_ack} = VEC[i];
      @(negedge clk); irq_in = v_irq;
      @(negedge clk); wr_en = 1; addr = 7'd0; wr_data = v_mask;
      @(negedge clk); addr = 7'd1; wr_data = v_ack;
      @(negedge clk); wr_en = 0;
      pend_m = (pend_m & ~v_ack) | v_irq;
      repeat (2) @(negedge clk);
      check({31'b0, cpu_irq}, {31'b0, |(pend_m & v_mask)}, $sformatf("R3 vec%0d irq", i));
      rd(7'd1, got); check(got, pend_m, $sformatf("R2/R4 vec%0d pending", i));
      rd(7'd0, got); check(got, v_mask, $sformatf("R5 vec%0d mask", i));
      rd(7'd2, got); check(got, v_irq, $sformatf("R1 vec%0d level", i));
    end

    // R1: synchronizer latency
    do_reset();
    @(negedge clk); irq_in = 32'h0000_0040;
    @(negedge clk); rd_en = 1; addr = 7'd2;
    @(negedge clk); rd_en = 0;
    check(rd_data, 32'h0, "R1 level not yet visible after edge k+1");
    rd(7'd2, got); check(got, 32'h0000_0040, "R1 level visible");

    // R7: edge counting
    do_reset();
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); irq_in[5] = 1;
      repeat (4) @(negedge clk);
      irq_in[5] = 0;
      repeat (3) @(negedge clk);
    end
    irq_in[31] = 1; irq_in[0] = 1;
    repeat (2) @(negedge clk); irq_in[31] = 0;
    repeat (10) @(negedge clk); irq_in[0] = 0;
    repeat (4) @(negedge clk);
    rd(cnt_addr(5, 0), got); check(got, 32'd3, "R7 counter5 low");
    rd(cnt_addr(5, 1), got); check(got, 32'd0, "R7/R8 counter5 high");
    rd(cnt_addr(31, 0), got); check(got, 32'd1, "R7 counter31");
    rd(cnt_addr(0, 0), got); check(got, 32'd1, "R7 held level counts once");
    rd(cnt_addr(1, 0), got); check(got, 32'd0, "R7 idle counter");
    rd(7'd3, got); check(got, 32'd0, "R8 address 3 reads zero");

    // R9: writes to read-only locations are ignored
    wr(7'd2, 32'hFFFF_FFFF);
    wr(7'd3, 32'hFFFF_FFFF);
    wr(cnt_addr(5, 0), 32'hFFFF_FFFF);
    rd(7'd2, got); check(got, 32'h0, "R9 level unchanged");
    rd(cnt_addr(5, 0), got); check(got, 32'd3, "R9 counter unchanged");
    rd(7'd0, got); check(got, 32'h0, "R9 mask unchanged");
    rd(7'd1, got); check(got, 32'h8000_0021, "R9 pending unchanged");
    check({31'b0, cpu_irq}, 32'h0, "R9 cpu_irq low");

    // R4: acknowledge in the same cycle as the input is high again
    @(negedge clk); irq_in[5] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 7'd1; wr_data = 32'h0000_0020;
    @(negedge clk); wr_en = 0;
    rd(7'd1, got); check(got, 32'h8000_0021, "R4 asserted line stays pending");
    finish_run();
  end
endmodule